// File: doc/BRIEF.md
# Three-Phase PWM Carrier with Speed Demand Mapping and Current Protection

This block produces the shared edge-aligned PWM reference for the three legs of a brushless motor bridge. A free-running carrier counts one period of 1200 clocks. The reference is high from the start of each period until the count reaches the active duty. Once per period the block emits a one-clock sample strobe, which tells a converter when to measure back-EMF. The duty comes from a 12-bit speed demand. A smaller demand code means more speed, because the block works on the headroom `4095 - demand`. The block also handles near-full demand, a startup cap, and a hold counter that commutation pulses count down.

Two comparator inputs protect the bridge. The current-limit flag ends the present pulse and leaves later periods alone. The overcurrent flag latches a fault and drops the bridge output enable. The fault clears only when the demand is brought back close to zero. A run flag with hysteresis tells the commutation logic whether the operator wants the motor turning. All pins are plain level or pulse signals sampled on the clock. No data stream crosses this boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `bldc_pwm_guard`

## Requirements
- R1: While reset is held, and right after it, `pwm_ref_o`, `sample_stb_o`, `fault_o` and `run_o` are 0 and `out_en_o` is 1. The active duty resets to 0, so the first period has no high time.
- R2: The carrier period is 1200 clocks, with counts 0 to 1199. The reference is high on counts below the active duty D, so it is high for D clocks, and it stays high for the whole period when D is 1200 or more.
- R3: The duty computed from the demand is `((4095 - demand) * 1200) >> 12`, using integer arithmetic.
- R4: A computed duty above 1195 is replaced by 1300, so the reference has no low time. A computed duty of exactly 1195 is used as is.
- R5: A hold counter caps the duty at 600 while it is nonzero. It loads 100 on the clock where `run_o` rises. It drops by one on each clock with `hold_dec_i` high, and it stops at 0.
- R6: A new duty, including the cap, is taken only on the clock edge that ends count 1199. Demand or hold changes in the middle of a period leave that period's pulse unchanged.
- R7: If `ilim_cmp_i` is high at a clock edge, the reference is low from the next count to the end of the period. The limit is always cleared at the period boundary, even when the flag is high on count 1199, so the following period is unaffected.
- R8: The sample strobe is high for exactly one clock per period. It fires at count 1100, or at count 100 when the period was loaded with `ots_req_i` high and a duty above 800. A duty of exactly 800 keeps the strobe at count 1100.
- R9: `ocp_cmp_i` high at a clock edge sets `fault_o` and clears `out_en_o` on that edge.
- R10: The fault stays set while the headroom `4095 - demand` is 100 or more. It clears, and `out_en_o` returns to 1, on the first edge where the headroom is below 100 and `ocp_cmp_i` is low. An overcurrent event on the same edge keeps it set.
- R11: `run_o` sets when the headroom is above 200 and clears when it is below 100. For headroom from 100 to 200, `run_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| demand_i | input | 12 | Speed demand code; 4095 means stop |
| ilim_cmp_i | input | 1 | Cycle-by-cycle current-limit comparator flag |
| ocp_cmp_i | input | 1 | Overcurrent comparator flag |
| ots_req_i | input | 1 | Request to move sampling into the on-time at high duty |
| hold_dec_i | input | 1 | Commutation pulse that counts the hold counter down |
| pwm_ref_o | output | 1 | Shared PWM reference for the three legs |
| sample_stb_o | output | 1 | One-clock back-EMF sample strobe per period |
| fault_o | output | 1 | Latched overcurrent fault |
| out_en_o | output | 1 | Bridge output enable |
| run_o | output | 1 | Run request with hysteresis |

## Verification
Changes to the duty and the sample position show up one period late. A change made anywhere in period N takes effect in period N+1. That is why the bench's driver tags each expected pulse width and strobe position with the period it belongs to, and the monitor scores a whole period after its count 1199. The current limit shows up on the count after the flag, so an event at count X gives a width of min(D, X+1). Fault, enable and run are one register away from their inputs, so they are read on the falling edge after the next rising edge. All stimulus changes on falling edges, and every output comes from registers, so no sample races the edge that changes it.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  // Which sampling point the carrier uses in the present period.
  typedef enum logic {
    SMP_LATE  = 1'b0,
    SMP_EARLY = 1'b1
  } smp_sel_e;
endpackage

// File: rtl/bpg_carrier.sv
module bpg_carrier
  import bpg_pkg::*;
#(
  parameter int PERIOD       = 1200,
  parameter int CNT_W        = 11,
  parameter int SAMPLE_LATE  = 1100,
  parameter int SAMPLE_EARLY = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_i,
  input  smp_sel_e         sel_i,
  input  logic             ilim_i,
  output logic             pwm_o,
  output logic             stb_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] S_LATE = CNT_W'(SAMPLE_LATE);
  localparam logic [CNT_W-1:0] S_EARL = CNT_W'(SAMPLE_EARLY);

  logic [CNT_W-1:0] cnt_q;
  logic             lim_q;

  assign wrap_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= 1'b0;
    end else begin
      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
      // period boundary always releases the limit
      if (wrap_o)      lim_q <= 1'b0;
      else if (ilim_i) lim_q <= 1'b1;
    end
  end

  assign pwm_o = (cnt_q < duty_i) && !lim_q;
  assign stb_o = (cnt_q == ((sel_i == SMP_EARLY) ? S_EARL : S_LATE));

  a_r7_limit_cuts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_i && !wrap_o) |=> !pwm_o);
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> !stb_o);
  a_r2_wrap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/bpg_duty.sv
module bpg_duty
  import bpg_pkg::*;
#(
  parameter int DMD_W      = 12,
  parameter int CNT_W      = 11,
  parameter int PERIOD     = 1200,
  parameter int OVR_THRESH = 1195,
  parameter int OVR_VAL    = 1300,
  parameter int CAP        = 600,
  parameter int HOLD_INIT  = 100,
  parameter int OTS_THRESH = 800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DMD_W-1:0] head_i,
  input  logic             wrap_i,
  input  logic             reload_i,
  input  logic             hold_dec_i,
  input  logic             ots_req_i,
  output logic [CNT_W-1:0] duty_o,
  output smp_sel_e         sel_o
);
  localparam int PW     = DMD_W + CNT_W;
  localparam int HOLD_W = $clog2(HOLD_INIT + 1);
  localparam logic [CNT_W-1:0] C_CAP = CNT_W'(CAP);
  localparam logic [CNT_W-1:0] C_OVT = CNT_W'(OVR_THRESH);
  localparam logic [CNT_W-1:0] C_OVV = CNT_W'(OVR_VAL);
  localparam logic [CNT_W-1:0] C_OTS = CNT_W'(OTS_THRESH);

  logic [PW-1:0]     prod;
  logic [CNT_W-1:0]  raw, full, capped;
  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  duty_q;
  smp_sel_e          sel_q;

  always_comb begin
    prod   = PW'(head_i) * PW'(PERIOD);
    raw    = CNT_W'(prod >> DMD_W);
    full   = (raw > C_OVT) ? C_OVV : raw;
    capped = ((hold_q != '0) && (full > C_CAP)) ? C_CAP : full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= HOLD_W'(HOLD_INIT);
      duty_q <= '0;
      sel_q  <= SMP_LATE;
    end else begin
      if (reload_i)                       hold_q <= HOLD_W'(HOLD_INIT);
      else if (hold_dec_i && hold_q != '0) hold_q <= hold_q - 1'b1;
      if (wrap_i) begin
        duty_q <= capped;
        sel_q  <= (ots_req_i && (capped > C_OTS)) ? SMP_EARLY : SMP_LATE;
      end
    end
  end

  assign duty_o = duty_q;
  assign sel_o  = sel_q;

  a_r6_duty_frozen_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(duty_o));
  a_r5_cap_applied: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && hold_q != '0) |=> (duty_o <= C_CAP));
  a_r4_no_partial_top: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> ((duty_o <= C_OVT) || (duty_o == C_OVV)));
  a_r5_hold_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q == '0 && !reload_i) |=> (hold_q == '0));
endmodule

// File: rtl/bpg_guard.sv
module bpg_guard #(
  parameter int DMD_W   = 12,
  parameter int RUN_ON  = 200,
  parameter int RUN_OFF = 100,
  parameter int CLR_LVL = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DMD_W-1:0] head_i,
  input  logic             ocp_i,
  output logic             run_o,
  output logic             run_rise_o,
  output logic             fault_o,
  output logic             out_en_o
);
  localparam logic [DMD_W-1:0] T_ON  = DMD_W'(RUN_ON);
  localparam logic [DMD_W-1:0] T_OFF = DMD_W'(RUN_OFF);
  localparam logic [DMD_W-1:0] T_CLR = DMD_W'(CLR_LVL);

  logic run_q, run_d, fault_q, fault_d, en_q;

  always_comb begin
    run_d = run_q;
    if (head_i > T_ON)       run_d = 1'b1;
    else if (head_i < T_OFF) run_d = 1'b0;
    fault_d = fault_q;
    if (ocp_i)                          fault_d = 1'b1;
    else if (fault_q && head_i < T_CLR) fault_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      fault_q <= 1'b0;
      en_q    <= 1'b1;
    end else begin
      run_q   <= run_d;
      fault_q <= fault_d;
      en_q    <= !fault_d;
    end
  end

  assign run_o      = run_q;
  assign run_rise_o = run_d && !run_q;
  assign fault_o    = fault_q;
  assign out_en_o   = en_q;

  a_r9_trip_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_i |=> (fault_o && !out_en_o));
  a_r10_fault_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && head_i >= T_CLR) |=> fault_o);
  a_r11_run_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (head_i > T_ON) |=> run_o);
  a_r11_run_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (head_i < T_OFF) |=> !run_o);
endmodule

// File: rtl/bldc_pwm_guard.sv
module bldc_pwm_guard
  import bpg_pkg::*;
#(
  parameter int DMD_W        = 12,
  parameter int PERIOD       = 1200,
  parameter int OVR_THRESH   = 1195,
  parameter int OVR_VAL      = 1300,
  parameter int CAP          = 600,
  parameter int HOLD_INIT    = 100,
  parameter int OTS_THRESH   = 800,
  parameter int SAMPLE_LATE  = 1100,
  parameter int SAMPLE_EARLY = 100,
  parameter int RUN_ON       = 200,
  parameter int RUN_OFF      = 100,
  parameter int CLR_LVL      = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DMD_W-1:0] demand_i,
  input  logic             ilim_cmp_i,
  input  logic             ocp_cmp_i,
  input  logic             ots_req_i,
  input  logic             hold_dec_i,
  output logic             pwm_ref_o,
  output logic             sample_stb_o,
  output logic             fault_o,
  output logic             out_en_o,
  output logic             run_o
);
  localparam int CNT_W = $clog2(OVR_VAL + 1);

  logic [DMD_W-1:0] head;
  logic [CNT_W-1:0] duty;
  smp_sel_e         sel;
  logic             wrap, run_rise;

  assign head = {DMD_W{1'b1}} - demand_i;

  bpg_guard #(
    .DMD_W(DMD_W), .RUN_ON(RUN_ON), .RUN_OFF(RUN_OFF), .CLR_LVL(CLR_LVL)
  ) u_guard (
    .clk(clk), .rst_n(rst_n), .head_i(head), .ocp_i(ocp_cmp_i),
    .run_o(run_o), .run_rise_o(run_rise), .fault_o(fault_o), .out_en_o(out_en_o)
  );

  bpg_duty #(
    .DMD_W(DMD_W), .CNT_W(CNT_W), .PERIOD(PERIOD), .OVR_THRESH(OVR_THRESH),
    .OVR_VAL(OVR_VAL), .CAP(CAP), .HOLD_INIT(HOLD_INIT), .OTS_THRESH(OTS_THRESH)
  ) u_duty (
    .clk(clk), .rst_n(rst_n), .head_i(head), .wrap_i(wrap), .reload_i(run_rise),
    .hold_dec_i(hold_dec_i), .ots_req_i(ots_req_i), .duty_o(duty), .sel_o(sel)
  );

  bpg_carrier #(
    .PERIOD(PERIOD), .CNT_W(CNT_W), .SAMPLE_LATE(SAMPLE_LATE), .SAMPLE_EARLY(SAMPLE_EARLY)
  ) u_carrier (
    .clk(clk), .rst_n(rst_n), .duty_i(duty), .sel_i(sel), .ilim_i(ilim_cmp_i),
    .pwm_o(pwm_ref_o), .stb_o(sample_stb_o), .wrap_o(wrap)
  );
endmodule

// File: tb/bldc_pwm_guard_bench.sv
`timescale 1ns/1ps
module bldc_pwm_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] demand = 12'd4095;
  logic        ilim = 1'b0, ocp = 1'b0, ots = 1'b0, hdec = 1'b0;
  logic        pwm, stb, fault, en, run;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bldc_pwm_guard u_bldc_pwm_guard (
    .clk(clk), .rst_n(rst_n), .demand_i(demand), .ilim_cmp_i(ilim),
    .ocp_cmp_i(ocp), .ots_req_i(ots), .hold_dec_i(hdec),
    .pwm_ref_o(pwm), .sample_stb_o(stb), .fault_o(fault),
    .out_en_o(en), .run_o(run)
  );

  // bench's own view of the carrier position
  int bphase = 0;
  int bperiod = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      bphase <= 0; bperiod <= 0;
    end else if (bphase == 1199) begin
      bphase <= 0; bperiod <= bperiod + 1;
    end else begin
      bphase <= bphase + 1;
    end
  end

  typedef struct {
    int    per;
    int    width;
    int    spos;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: scores one whole period at a time
  int hi = 0, scnt = 0, spos = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bphase == 0) begin hi = 0; scnt = 0; spos = -1; end
      if (pwm) hi++;
      if (stb) begin scnt++; spos = bphase; end
      if (bphase == 1199) begin
        while (sb.size() > 0 && sb[0].per < bperiod) begin
          check(1'b0, sb[0].tag, "period missed", bperiod, sb[0].per);
          void'(sb.pop_front());
        end
        if (sb.size() > 0 && sb[0].per == bperiod) begin
          exp_t e;
          e = sb.pop_front();
          check(hi == e.width, e.tag, "pulse width", hi, e.width);
          check(scnt == 1, "R8", "strobes per period", scnt, 1);
          check(spos == e.spos, e.tag, "strobe position", spos, e.spos);
        end
      end
    end
  end

  // expected duty from R3, R4, R5
  function automatic int exp_duty(input int d, input bit cap);
    int h, r;
    h = 4095 - d;
    r = (h * 1200) / 4096;
    if (r > 1195) r = 1300;
    if (cap && r > 600) r = 600;
    return r;
  endfunction

  task automatic align0();
    while (bphase != 0) @(negedge clk);
  endtask

  task automatic run_period(input int d, input bit o, input bit cap,
                            input int lim_at, input string tag);
    int du, wf, wl, sp;
    exp_t e;
    align0();
    demand = 12'(d);
    ots = o;
    du = exp_duty(d, cap);
    wf = (du > 1200) ? 1200 : du;
    wl = (lim_at < 0) ? wf : ((lim_at + 1 < wf) ? lim_at + 1 : wf);
    sp = (o && du > 800) ? 100 : 1100;
    e.per = bperiod + 1; e.width = wl; e.spos = sp; e.tag = tag;
    sb.push_back(e);
    e.per = bperiod + 2; e.width = wf; e.spos = sp; e.tag = tag;
    sb.push_back(e);
    repeat (1200) @(negedge clk);
    if (lim_at >= 0) begin
      repeat (lim_at) @(negedge clk);
      ilim = 1'b1;
      @(negedge clk);
      ilim = 1'b0;
    end
    @(negedge clk);
    align0();
  endtask

  task automatic hold_pulses(input int n);
    repeat (n) begin hdec = 1'b1; @(negedge clk); end
    hdec = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    exp_t e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pwm == 1'b0, "R1", "pwm in reset", pwm, 0);
    check(stb == 1'b0, "R1", "strobe in reset", stb, 0);
    check(fault == 1'b0, "R1", "fault in reset", fault, 0);
    check(en == 1'b1, "R1", "enable in reset", en, 1);
    check(run == 1'b0, "R1", "run in reset", run, 0);
    e0.per = 0; e0.width = 0; e0.spos = 1100; e0.tag = "R1";
    sb.push_back(e0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);

    run_period(4095, 1'b0, 1'b1, -1, "R3");   // headroom 0 -> 0
    run_period(3071, 1'b0, 1'b1, -1, "R3");   // 1024 -> 300, run rises
    run_period(2047, 1'b0, 1'b1, -1, "R2");   // 2048 -> 600
    run_period(0,    1'b0, 1'b1, -1, "R5");   // capped at 600
    hold_pulses(99);
    run_period(0,    1'b0, 1'b1, -1, "R5");   // hold at 1 still caps
    hold_pulses(1);
    run_period(16,   1'b0, 1'b0, -1, "R4");   // exactly 1195
    run_period(12,   1'b0, 1'b0, -1, "R4");   // 1196 -> full on
    run_period(0,    1'b0, 1'b0, -1, "R2");   // full on
    run_period(1023, 1'b1, 1'b0, -1, "R8");   // 900, early strobe
    run_period(1364, 1'b1, 1'b0, -1, "R8");   // 800, late strobe
    run_period(1023, 1'b0, 1'b0, -1, "R8");   // no request, late
    run_period(2047, 1'b0, 1'b0, 299, "R7");  // limit at count 299
    run_period(2047, 1'b0, 1'b0, 0, "R7");    // limit at count 0
    run_period(12,   1'b0, 1'b0, 1199, "R7"); // limit on last count

    // R11 hysteresis (run is 1 here)
    demand = 12'd3945; repeat (2) @(negedge clk);
    check(run == 1'b1, "R11", "run in band stays set", run, 1);
    demand = 12'd4045; repeat (2) @(negedge clk);
    check(run == 1'b0, "R11", "run clears below 100", run, 0);
    demand = 12'd3945; repeat (2) @(negedge clk);
    check(run == 1'b0, "R11", "run in band stays clear", run, 0);
    demand = 12'd0; repeat (2) @(negedge clk);
    check(run == 1'b1, "R11", "run sets above 200", run, 1);
    // run rose again: hold reloaded, cap back (R5)
    run_period(0, 1'b0, 1'b1, -1, "R5");

    // R9 / R10 trip and release
    ocp = 1'b1; @(negedge clk); ocp = 1'b0;
    check(fault == 1'b1, "R9", "fault after trip", fault, 1);
    check(en == 1'b0, "R9", "enable after trip", en, 0);
    demand = 12'd3945; repeat (3) @(negedge clk);
    check(fault == 1'b1, "R10", "fault held at headroom 150", fault, 1);
    check(en == 1'b0, "R10", "enable held low", en, 0);
    demand = 12'd4045; ocp = 1'b1; @(negedge clk);
    check(fault == 1'b1, "R10", "trip wins over release", fault, 1);
    ocp = 1'b0; @(negedge clk);
    check(fault == 1'b0, "R10", "fault released", fault, 0);
    check(en == 1'b1, "R10", "enable restored", en, 1);

    repeat (1300) @(negedge clk);
    check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
    summary();
    $finish;
  end
endmodule